// File: doc/BRIEF.md
# Frequency-Jittered PWM Cycle Oscillator

This block is the timing core of a fixed-frequency current-mode switching controller. From a fixed system clock it produces a one-clock pulse that opens each switching cycle. It also produces three windows measured from that pulse. The first is a blanking window, during which the current comparator must be ignored. The second is a minimum on-time window, during which the switch may not be turned off. The third is a maximum-duty flag, which forces the switch off for the last quarter of the period.

To spread conducted emission over many sidebands, the period is not constant. A slow triangle sweep moves the period reload value one clock count at a time. It covers a band of plus and minus a deviation around the nominal period, and one full sweep lasts 4 ms (a 250 Hz modulation rate). The deviation is about 4 kHz at the 60 kHz operating point and about 8 kHz at the 115 kHz operating point. A new period value takes effect only when a cycle ends, so no cycle is ever cut short. All counts are derived at elaboration from the clock frequency and the variant parameter. An enable input gates the whole block: while it is low, every counter sits at its start value and no output is asserted.

Top module: `jitter_osc`

## Requirements
- R1: The nominal period is round(CLK_HZ / F) clocks, with F = 60 kHz when HIGH_VARIANT = 0 and F = 115 kHz when HIGH_VARIANT = 1. The first cycle after enable has exactly this length.
- R2: The cycle length sweeps over every value from nominal − DEV to nominal + DEV and never leaves that band. DEV is round(nominal × Fdev / F), with Fdev = 4 kHz for the low variant and 8 kHz for the high variant.
- R3: The sweep is a triangle of 4·DEV steps, spaced (CLK_HZ/250)/(4·DEV) clocks apart. Successive arrivals at the longest period are therefore about 4 ms apart, within one period.
- R4: The period value changes only at a cycle boundary, and two consecutive cycles differ in length by at most one clock.
- R5: `cycle_start` is high for exactly one clock at the first count of every cycle.
- R6: For a cycle of P clocks, `max_duty` is low for the first P − floor(P/4) clocks of the cycle and high for the remaining floor(P/4) clocks.
- R7: `blank` is high for the first ceil(300 ns × CLK_HZ) clocks of every cycle and low otherwise.
- R8: `min_on` is high for the first ceil(480 ns × CLK_HZ) clocks of every cycle and low otherwise.
- R9: While `enable` is low, all four outputs are low from the next clock on. After `enable` returns high, `cycle_start` rises one clock later, and the first cycle again has the nominal length, because the sweep restarts from its centre.
- R10: While `rst_n` is low, all outputs are low, whatever the value of `enable`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock of CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run control; low holds all counters at their start values |
| cycle_start | output | 1 | One-clock pulse opening each switching cycle |
| max_duty | output | 1 | High during the final quarter of the cycle |
| blank | output | 1 | Leading-edge blanking window |
| min_on | output | 1 | Minimum on-time window |

## Verification
The bench instantiates the block twice at a 6 MHz CLK_HZ, once per variant. This gives periods of 100 and 52 clocks and deviations of 7 and 4 counts. With these values a whole 4 ms triangle fits in a few tens of thousands of clocks, and both band edges and the sweep spacing can be observed directly. Blanking and minimum on-time come out at 2 and 3 clocks, so the ceiling rounding of both windows is exercised. The default 48 MHz configuration is only elaborated.

// File: rtl/jitter_pkg.sv
package jitter_pkg;

    // Integer division rounded to nearest
    function automatic int round_div(input longint num, input longint den);
        return int'((num + den / 2) / den);
    endfunction

    // Clock count covering a duration in ns, rounded up
    function automatic int ns_to_clks(input longint clk_hz, input longint ns);
        return int'(((clk_hz / 1000) * ns + 999_999) / 1_000_000);
    endfunction

    typedef enum logic {
        SWEEP_DOWN = 1'b0,
        SWEEP_UP   = 1'b1
    } sweep_dir_e;

endpackage

// File: rtl/jitter_sweep.sv
// Triangle sweep of the period reload value, one count per step.
module jitter_sweep #(
    parameter int PER_MIN = 747,
    parameter int DEV     = 53,
    parameter int STEP    = 905,
    parameter int PER_W   = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    output logic [PER_W-1:0] target
);
    import jitter_pkg::*;

    localparam int LVL_W  = $clog2(2 * DEV + 1);
    localparam int TICK_W = $clog2(STEP + 1);

    typedef struct packed {
        logic [LVL_W-1:0]  level;
        sweep_dir_e        dir;
        logic [TICK_W-1:0] tick;
    } sweep_t;

    localparam sweep_t SWEEP_RST = '{level: LVL_W'(DEV), dir: SWEEP_UP, tick: '0};

    sweep_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!enable) begin
            st_d = SWEEP_RST;
        end else if (st_q.tick == TICK_W'(STEP - 1)) begin
            st_d.tick = '0;
            if (st_q.dir == SWEEP_UP) begin
                st_d.level = st_q.level + 1'b1;
                if (st_q.level + 1'b1 == LVL_W'(2 * DEV)) st_d.dir = SWEEP_DOWN;
            end else begin
                st_d.level = st_q.level - 1'b1;
                if (st_q.level == LVL_W'(1)) st_d.dir = SWEEP_UP;
            end
        end else begin
            st_d.tick = st_q.tick + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SWEEP_RST;
        else        st_q <= st_d;
    end

    assign target = PER_W'(PER_MIN) + PER_W'(st_q.level);

endmodule

// File: rtl/jitter_cycle.sv
// Cycle counter with reload at the boundary and window decoding.
module jitter_cycle #(
    parameter int PER_NOM = 800,
    parameter int BLANK   = 15,
    parameter int MINON   = 24,
    parameter int PER_W   = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [PER_W-1:0] target,
    output logic             cycle_start,
    output logic             max_duty,
    output logic             blank,
    output logic             min_on,
    output logic             running,
    output logic [PER_W-1:0] cur_period
);
    typedef struct packed {
        logic             run;
        logic [PER_W-1:0] cnt;
        logic [PER_W-1:0] period;
        logic [PER_W-1:0] limit;
    } cyc_t;

    localparam logic [PER_W-1:0] NOM_P   = PER_W'(PER_NOM);
    localparam logic [PER_W-1:0] NOM_LIM = NOM_P - (NOM_P >> 2);
    localparam cyc_t CYC_RST = '{run: 1'b0, cnt: '0, period: NOM_P, limit: NOM_LIM};

    cyc_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!enable) begin
            st_d = CYC_RST;
        end else if (!st_q.run) begin
            st_d.run = 1'b1;
            st_d.cnt = '0;
        end else if (st_q.cnt == st_q.period - 1'b1) begin
            st_d.cnt    = '0;
            st_d.period = target;
            st_d.limit  = target - (target >> 2);
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CYC_RST;
        else        st_q <= st_d;
    end

    assign cycle_start = st_q.run && (st_q.cnt == '0);
    assign blank       = st_q.run && (st_q.cnt < PER_W'(BLANK));
    assign min_on      = st_q.run && (st_q.cnt < PER_W'(MINON));
    assign max_duty    = st_q.run && (st_q.cnt >= st_q.limit);
    assign running     = st_q.run;
    assign cur_period  = st_q.period;

endmodule

// File: rtl/jitter_osc.sv
module jitter_osc #(
    parameter int CLK_HZ       = 48_000_000,
    parameter bit HIGH_VARIANT = 1'b0,
    parameter int MOD_HZ       = 250,
    parameter int BLANK_NS     = 300,
    parameter int MINON_NS     = 480
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    output logic cycle_start,
    output logic max_duty,
    output logic blank,
    output logic min_on
);
    import jitter_pkg::*;

    localparam int F_NOM   = HIGH_VARIANT ? 115_000 : 60_000;
    localparam int F_DEV   = HIGH_VARIANT ? 8_000 : 4_000;
    localparam int PER_NOM = round_div(CLK_HZ, F_NOM);
    localparam int DEV     = round_div(longint'(PER_NOM) * F_DEV, F_NOM);
    localparam int PER_MIN = PER_NOM - DEV;
    localparam int PER_MAX = PER_NOM + DEV;
    localparam int PER_W   = $clog2(PER_MAX + 1);
    localparam int DEV_NZ  = (DEV > 0) ? DEV : 1;
    localparam int STEP_RAW = (CLK_HZ / MOD_HZ) / (4 * DEV_NZ);
    localparam int STEP    = (STEP_RAW > 0) ? STEP_RAW : 1;
    localparam int BLANK   = ns_to_clks(CLK_HZ, BLANK_NS);
    localparam int MINON   = ns_to_clks(CLK_HZ, MINON_NS);

    logic [PER_W-1:0] target;
    logic [PER_W-1:0] cur_period;
    logic             running;

    generate
        if (DEV > 0) begin : g_sweep
            jitter_sweep #(
                .PER_MIN (PER_MIN),
                .DEV     (DEV),
                .STEP    (STEP),
                .PER_W   (PER_W)
            ) u_sweep (
                .clk    (clk),
                .rst_n  (rst_n),
                .enable (enable),
                .target (target)
            );
        end else begin : g_fixed
            assign target = PER_W'(PER_NOM);
        end
    endgenerate

    jitter_cycle #(
        .PER_NOM (PER_NOM),
        .BLANK   (BLANK),
        .MINON   (MINON),
        .PER_W   (PER_W)
    ) u_cycle (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .target      (target),
        .cycle_start (cycle_start),
        .max_duty    (max_duty),
        .blank       (blank),
        .min_on      (min_on),
        .running     (running),
        .cur_period  (cur_period)
    );

endmodule

// File: rtl/jitter_osc_chk.sv
module jitter_osc_chk #(
    parameter int PER_MIN = 747,
    parameter int PER_MAX = 853,
    parameter int PER_W   = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             cycle_start,
    input logic             max_duty,
    input logic             blank,
    input logic             min_on,
    input logic             running,
    input logic [PER_W-1:0] cur_period
);
    p_idle_when_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !(cycle_start || max_duty || blank || min_on));

    p_single_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_start |=> !cycle_start);

    p_no_maxduty_at_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_start |-> !max_duty);

    p_blank_within_minon_r7: assert property (@(posedge clk) disable iff (!rst_n)
        blank |-> min_on);

    p_period_in_band_r2: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (cur_period >= PER_W'(PER_MIN) && cur_period <= PER_W'(PER_MAX)));

    p_reload_on_boundary_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (running && $past(running) && !$stable(cur_period)) |-> cycle_start);

    p_unit_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (running && $past(running) && !$stable(cur_period)) |->
        (cur_period == $past(cur_period) + 1'b1 || cur_period + 1'b1 == $past(cur_period)));

endmodule

bind jitter_osc jitter_osc_chk #(
    .PER_MIN (PER_MIN),
    .PER_MAX (PER_MAX),
    .PER_W   (PER_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .cycle_start (cycle_start),
    .max_duty    (max_duty),
    .blank       (blank),
    .min_on      (min_on),
    .running     (running),
    .cur_period  (cur_period)
);

// File: tb/jitter_osc_tb.sv
module jitter_osc_tb;

    typedef struct packed {
        int nom;
        int dev;
        int blank;
        int minon;
        int tri_clks;
    } exp_t;

    // expected values at CLK_HZ = 6 MHz: index 0 low variant, index 1 high variant
    localparam exp_t TBL [2] = '{
        '{nom: 100, dev: 7, blank: 2, minon: 3, tri_clks: 24000},
        '{nom: 52,  dev: 4, blank: 2, minon: 3, tri_clks: 24000}
    };
    localparam int RUN_CLKS = 33000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en [2];
    logic st [2], md [2], bl [2], mo [2];

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    int wd       = 0;

    always #2 clk = ~clk;

    jitter_osc #(.CLK_HZ(6_000_000), .HIGH_VARIANT(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .enable(en[0]),
        .cycle_start(st[0]), .max_duty(md[0]), .blank(bl[0]), .min_on(mo[0]));

    jitter_osc #(.CLK_HZ(6_000_000), .HIGH_VARIANT(1'b1)) u_dut_hi (
        .clk(clk), .rst_n(rst_n), .enable(en[1]),
        .cycle_start(st[1]), .max_duty(md[1]), .blank(bl[1]), .min_on(mo[1]));

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd >= 190000 && !done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below %0d", wd, 190000);
            finish_run();
        end
    end

    task automatic run_variant(input int v);
        exp_t e;
        int idx, p, prev_p, first_p, min_p, max_p, nstart;
        int bl_cnt, mo_cnt, md_cnt, md_first;
        int err_step, err_bl, err_mo, err_md, err_other;
        int t, t_max1, t_max2;
        bit have;
        e = TBL[v];
        idx = 0; prev_p = 0; first_p = 0; min_p = 1 << 20; max_p = 0; nstart = 0;
        bl_cnt = 0; mo_cnt = 0; md_cnt = 0; md_first = -1;
        err_step = 0; err_bl = 0; err_mo = 0; err_md = 0; err_other = 0;
        t_max1 = -1; t_max2 = -1; have = 1'b0;
        @(negedge clk);
        en[v] = 1'b1;
        en[1-v] = 1'b0;
        for (int c = 0; c < RUN_CLKS; c++) begin
            @(negedge clk);
            t = c;
            if (st[1-v] || md[1-v] || bl[1-v] || mo[1-v]) err_other++;
            if (st[v]) begin
                if (have) begin
                    p = idx;
                    nstart++;
                    if (nstart == 1) first_p = p;
                    if (p < min_p) min_p = p;
                    if (p > max_p) max_p = p;
                    if (prev_p != 0 && (p > prev_p + 1 || p + 1 < prev_p)) err_step++;
                    if (bl_cnt != e.blank) err_bl++;
                    if (mo_cnt != e.minon) err_mo++;
                    if (md_first != p - p / 4 || md_cnt != p / 4) err_md++;
                    if (p == e.nom + e.dev && prev_p != p) begin
                        if (t_max1 < 0) t_max1 = t;
                        else if (t_max2 < 0) t_max2 = t;
                    end
                    prev_p = p;
                end
                have = 1'b1;
                idx = 0; bl_cnt = 0; mo_cnt = 0; md_cnt = 0; md_first = -1;
            end
            if (have) begin
                if (bl[v]) begin
                    bl_cnt++;
                    if (idx >= e.blank) err_bl++;
                end
                if (mo[v]) begin
                    mo_cnt++;
                    if (idx >= e.minon) err_mo++;
                end
                if (md[v]) begin
                    md_cnt++;
                    if (md_first < 0) md_first = idx;
                end
                idx++;
            end
        end
        en[v] = 1'b0;
        check(first_p == e.nom, "R1", "first period", first_p, e.nom);
        check(min_p == e.nom - e.dev, "R2", "shortest period", min_p, e.nom - e.dev);
        check(max_p == e.nom + e.dev, "R2", "longest period", max_p, e.nom + e.dev);
        check(t_max2 > 0 && (t_max2 - t_max1 - e.tri_clks) <= e.nom + e.dev
              && (e.tri_clks - (t_max2 - t_max1)) <= e.nom + e.dev,
              "R3", "sweep repeat clocks", t_max2 - t_max1, e.tri_clks);
        check(err_step == 0, "R4", "period jumps over one count", err_step, 0);
        check(nstart > 200, "R5", "cycle starts seen", nstart, 200);
        check(err_md == 0, "R6", "max duty window errors", err_md, 0);
        check(err_bl == 0, "R7", "blanking window errors", err_bl, 0);
        check(err_mo == 0, "R8", "min on window errors", err_mo, 0);
        check(err_other == 0, "R9", "activity on disabled instance", err_other, 0);
    endtask

    initial begin
        int bad;
        int p;
        en[0] = 1'b1;
        en[1] = 1'b1;
        // R10: reset dominates enable
        bad = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            for (int v = 0; v < 2; v++)
                if (st[v] || md[v] || bl[v] || mo[v]) bad++;
        end
        check(bad == 0, "R10", "outputs during reset", bad, 0);
        en[0] = 1'b0;
        en[1] = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        for (int v = 0; v < 2; v++) run_variant(v);

        // R9: disable mid-run, then restart from nominal
        en[0] = 1'b1;
        repeat (3000) @(negedge clk);
        en[0] = 1'b0;
        bad = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (st[0] || md[0] || bl[0] || mo[0]) bad++;
        end
        check(bad == 0, "R9", "outputs while disabled", bad, 0);
        en[0] = 1'b1;
        @(negedge clk);
        check(st[0] == 1'b1, "R9", "start one clock after enable", st[0], 1);
        p = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            p++;
            if (st[0]) break;
        end
        check(p == TBL[0].nom, "R9", "first period after re-enable", p, TBL[0].nom);
        en[0] = 1'b0;
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule